// File: doc/BRIEF.md
# Paged Microcode Register Window

This block is the word-addressed register slave of a microcoded vertex processor. Its flat address space has three regions. The first is a small bank of configuration and status words. The second is a 128-entry window onto the general registers. The third is a 512-word window into a 2048-word microcode store, and a page register chooses which quarter of the store that window reaches. Only full 32-bit transfers are supported, and the byte address is turned into a word offset by dropping its two low bits.

The execution engine does not use the bus. It has its own ports into the stores: a combinational read and a write on the general registers, and a combinational read on the microcode store. A bus write to the control word with bit 0 set raises a one-cycle start strobe toward the engine. Reads of the control word return the engine's busy state. Accesses that hit no region read as zero and change nothing, and they set a sticky error flag. A misaligned byte address also sets that flag, but the access is still carried out on the addressed word.

Top module: `pmc_csr_window`

## Requirements
- R1: The word offset is byte address bits [11:2], and bits [1:0] do not change which word is accessed. A nonzero value in bits [1:0] sets the error flag.
- R2: Word offsets 1 to 11 are plain 32-bit storage words that read back the value last written. In order, they hold the mesh base, the horizontal last index, the vertical last index, the code page, the vertex count, the collisions, the stray writes, the last DMA address, the program counter, the data-register base and the code base.
- R3: Word offsets 0x100 to 0x17F read and write general registers 0 to 127 one-to-one.
- R4: Word offsets 0x200 to 0x3FF reach microcode word ((512 × page) + (offset − 0x200)) mod 2048. The page is the value at word offset 4, so only its two low bits matter.
- R5: A write to word offset 0 with data bit 0 set drives start_pulse high for exactly the next cycle. Any write to offset 0 stores nothing, and a write with bit 0 clear gives no pulse.
- R6: A read of word offset 0 returns eng_busy in bit 0 and zeros in bits 31:1.
- R7: A read of an undecoded offset (12 to 0xFF, or 0x180 to 0x1FF) returns zero. A write to one of these offsets changes no stored word.
- R8: bus_err is 0 after reset. It becomes 1 after any undecoded or misaligned access and stays 1 until the next reset.
- R9: When a bus write and an engine write hit the same general register in one cycle, the engine's value is stored.
- R10: Reset clears every configuration word, every general register, every microcode word, bus_rdata, start_pulse and bus_err to zero.
- R11: bus_rdata is updated on the clock edge that accepts a read, and it holds its value until the next read.
- R12: eng_gpr_rdata and eng_code_rdata show the addressed stored word with no cycle of delay, including words written over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Sticky bad-access flag |
| start_pulse | output | 1 | One-cycle start strobe to the engine |
| eng_busy | input | 1 | Engine busy status |
| eng_gpr_we | input | 1 | Engine general-register write enable |
| eng_gpr_waddr | input | 7 | Engine write index |
| eng_gpr_wdata | input | 32 | Engine write data |
| eng_gpr_raddr | input | 7 | Engine read index |
| eng_gpr_rdata | output | 32 | General register at eng_gpr_raddr |
| eng_code_raddr | input | 11 | Engine microcode read index |
| eng_code_rdata | output | 32 | Microcode word at eng_code_raddr |

## Verification
Two situations are hard to reach from the ports. The first is a bus write and an engine write landing on the same general register in one cycle. The stimulus lines these up by driving the engine write port in the same half-cycle as a bus write and then reading the register back over the bus. The second is page aliasing. Words are written in several pages, including the last word of the top page. They are then read back through the engine port at their absolute indices, and once more through the window with a page value above 3, which must wrap to a lower page.

// File: rtl/pmc_csr_window.sv
module pmc_csr_window #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CSR_N      = 12,
  parameter int GPR_N      = 128,
  parameter int GPR_BASE   = 256,
  parameter int CODE_WORDS = 2048,
  parameter int WIN_WORDS  = 512,
  parameter int CODE_BASE  = 512,
  parameter int PAGE_SLOT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          bus_err,
  output logic                          start_pulse,
  input  logic                          eng_busy,
  input  logic                          eng_gpr_we,
  input  logic [$clog2(GPR_N)-1:0]      eng_gpr_waddr,
  input  logic [DATA_W-1:0]             eng_gpr_wdata,
  input  logic [$clog2(GPR_N)-1:0]      eng_gpr_raddr,
  output logic [DATA_W-1:0]             eng_gpr_rdata,
  input  logic [$clog2(CODE_WORDS)-1:0] eng_code_raddr,
  output logic [DATA_W-1:0]             eng_code_rdata
);
  localparam int WA      = ADDR_W - 2;
  localparam int CSR_AW  = $clog2(CSR_N);
  localparam int GPR_AW  = $clog2(GPR_N);
  localparam int CODE_AW = $clog2(CODE_WORDS);
  localparam int WIN_AW  = $clog2(WIN_WORDS);
  localparam int PG_W    = CODE_AW - WIN_AW;

  logic [DATA_W-1:0] csr  [CSR_N];
  logic [DATA_W-1:0] gpr  [GPR_N];
  logic [DATA_W-1:0] code [CODE_WORDS];

  wire [WA-1:0] woff      = bus_addr[ADDR_W-1:2];
  wire          misalign  = |bus_addr[1:0];
  wire          hit_ctl   = woff == '0;
  wire          hit_csr   = woff < WA'(CSR_N);
  wire          hit_gpr   = woff[WA-1:GPR_AW] == (WA-GPR_AW)'(GPR_BASE >> GPR_AW);
  wire          hit_code  = woff[WA-1:WIN_AW] == (WA-WIN_AW)'(CODE_BASE >> WIN_AW);
  wire          hit_any   = hit_csr | hit_gpr | hit_code;
  wire          wr        = bus_valid & bus_we;
  wire          rd        = bus_valid & ~bus_we;

  wire [CSR_AW-1:0]  cidx     = woff[CSR_AW-1:0];
  wire [GPR_AW-1:0]  gidx     = woff[GPR_AW-1:0];
  wire [CODE_AW-1:0] code_idx = {csr[PAGE_SLOT][PG_W-1:0], woff[WIN_AW-1:0]};

  logic [DATA_W-1:0] rmux;

  always_comb begin
    if (hit_ctl)       rmux = {{(DATA_W-1){1'b0}}, eng_busy};
    else if (hit_csr)  rmux = csr[cidx];
    else if (hit_gpr)  rmux = gpr[gidx];
    else if (hit_code) rmux = code[code_idx];
    else               rmux = '0;
  end

  assign eng_gpr_rdata  = gpr[eng_gpr_raddr];
  assign eng_code_rdata = code[eng_code_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CSR_N; i++)      csr[i]  <= '0;
      for (int i = 0; i < GPR_N; i++)      gpr[i]  <= '0;
      for (int i = 0; i < CODE_WORDS; i++) code[i] <= '0;
      bus_rdata   <= '0;
      bus_err     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      if (wr && hit_csr && !hit_ctl) csr[cidx] <= bus_wdata;
      if (wr && hit_gpr)             gpr[gidx] <= bus_wdata;
      if (eng_gpr_we)                gpr[eng_gpr_waddr] <= eng_gpr_wdata;
      if (wr && hit_code)            code[code_idx] <= bus_wdata;
      if (rd)                        bus_rdata <= rmux;
      start_pulse <= wr & hit_ctl & bus_wdata[0];
      bus_err     <= bus_err | (bus_valid & (~hit_any | misalign));
    end
  end

  AST_START_FOLLOWS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr[ADDR_W-1:2] == '0 && bus_wdata[0]) |=> start_pulse) // R5
    else $error("start pulse missing");
  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_we && bus_addr[ADDR_W-1:2] == '0 && bus_wdata[0]) |=> !start_pulse) // R5
    else $error("unexpected start pulse");
  AST_CTL_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr[ADDR_W-1:2] == '0) |=> bus_rdata == {{(DATA_W-1){1'b0}}, $past(eng_busy)}) // R6
    else $error("control read mismatch");
  AST_UNDECODED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_any) |=> bus_rdata == '0) // R7
    else $error("undecoded read nonzero");
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err) // R8
    else $error("error flag dropped");
  AST_ENGINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_gpr_we && wr && hit_gpr && gidx == eng_gpr_waddr) |=> gpr[$past(eng_gpr_waddr)] == $past(eng_gpr_wdata)) // R9
    else $error("engine write lost");
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata)) // R11
    else $error("read data moved without a read");
endmodule

// File: tb/test_pmc_csr_window.sv
module test_pmc_csr_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, start_pulse;
  logic        eng_busy = 1'b0, eng_gpr_we = 1'b0;
  logic [6:0]  eng_gpr_waddr = '0, eng_gpr_raddr = '0;
  logic [31:0] eng_gpr_wdata = '0;
  logic [31:0] eng_gpr_rdata, eng_code_rdata;
  logic [10:0] eng_code_raddr = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pmc_csr_window i_pmc_csr_window (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; eng_gpr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && bus_valid && !bus_we) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", bus_rdata, '0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic logic [11:0] w(input int off);
    return 12'(off << 2);
  endfunction

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(bus_rdata == 0 && start_pulse == 0 && bus_err == 0, "R10 reset outputs",
          {bus_rdata[29:0], start_pulse, bus_err}, '0);

    for (int i = 1; i < 12; i++) wr(w(i), 32'hA500_0000 + i);
    for (int i = 1; i < 12; i++) rd(w(i), 32'hA500_0000 + i, "R2 config word");

    wr(w(0), 32'h1);
    check(start_pulse == 1'b1, "R5 start pulse high", {31'b0, start_pulse}, 1);
    @(negedge clk);
    check(start_pulse == 1'b0, "R5 start pulse one cycle", {31'b0, start_pulse}, 0);
    wr(w(0), 32'hFFFF_FFFE);
    check(start_pulse == 1'b0, "R5 no pulse with bit0 clear", {31'b0, start_pulse}, 0);
    rd(w(0), 32'h0, "R6 control idle, R5 nothing stored");
    eng_busy = 1'b1;
    rd(w(0), 32'h1, "R6 control busy");
    eng_busy = 1'b0;

    wr(w(12'h105), 32'hCAFE_0005);
    wr(w(12'h17F), 32'hCAFE_007F);
    rd(w(12'h105), 32'hCAFE_0005, "R3 gpr 5");
    rd(w(12'h17F), 32'hCAFE_007F, "R3 gpr 127");
    eng_gpr_raddr = 7'd127;
    #1 check(eng_gpr_rdata == 32'hCAFE_007F, "R12 engine gpr read", eng_gpr_rdata, 32'hCAFE_007F);
    @(negedge clk);
    check(bus_rdata == 32'hCAFE_007F, "R11 read data holds", bus_rdata, 32'hCAFE_007F);

    wr(w(4), 32'd0); wr(w(12'h200), 32'h1111_0000);
    wr(w(4), 32'd3); wr(w(12'h3FF), 32'h3333_01FF);
    wr(w(4), 32'd2); wr(w(12'h205), 32'h2222_0005);
    eng_code_raddr = 11'd0;
    #1 check(eng_code_rdata == 32'h1111_0000, "R4 page 0 word 0", eng_code_rdata, 32'h1111_0000);
    eng_code_raddr = 11'd2047;
    #1 check(eng_code_rdata == 32'h3333_01FF, "R4 page 3 last word", eng_code_rdata, 32'h3333_01FF);
    eng_code_raddr = 11'd1029;
    #1 check(eng_code_rdata == 32'h2222_0005, "R4 page 2 word 5", eng_code_rdata, 32'h2222_0005);
    rd(w(12'h205), 32'h2222_0005, "R4 window read page 2");
    wr(w(4), 32'd6);
    rd(w(12'h205), 32'h2222_0005, "R4 page 6 wraps to 2");
    wr(w(4), 32'd3);
    rd(w(12'h200), 32'h0, "R4 page 3 word 0 untouched");
    rd(w(12'h3FF), 32'h3333_01FF, "R4 window read page 3");

    check(bus_err == 1'b0, "R8 no error after legal accesses", {31'b0, bus_err}, 0);
    rd(w(12'h105) | 12'h3, 32'hCAFE_0005, "R1 low address bits ignored");
    check(bus_err == 1'b1, "R1 misaligned sets error", {31'b0, bus_err}, 1);
    do_reset();
    check(bus_err == 1'b0, "R8 reset clears error", {31'b0, bus_err}, 0);

    wr(w(12'h100), 32'h0);
    wr(w(12'h180), 32'hDEAD_BEEF);
    wr(w(12), 32'hDEAD_BEEF);
    rd(w(12'h040), 32'h0, "R7 undecoded read zero");
    rd(w(12'h180), 32'h0, "R7 undecoded read zero");
    rd(w(12'h100), 32'h0, "R7 write ignored gpr 0");
    rd(w(11), 32'h0, "R7 write ignored config 11");
    check(bus_err == 1'b1, "R8 error set", {31'b0, bus_err}, 1);
    @(negedge clk); @(negedge clk);
    check(bus_err == 1'b1, "R8 error sticky", {31'b0, bus_err}, 1);

    @(negedge clk);
    eng_gpr_we = 1'b1; eng_gpr_waddr = 7'd9; eng_gpr_wdata = 32'h0E0E_0009;
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = w(12'h109); bus_wdata = 32'hB0B0_0009;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; eng_gpr_we = 1'b0;
    rd(w(12'h109), 32'h0E0E_0009, "R9 engine wins");
    eng_gpr_we = 1'b1; eng_gpr_waddr = 7'd10; eng_gpr_wdata = 32'h0E0E_000A;
    @(negedge clk); eng_gpr_we = 1'b0;
    rd(w(12'h10A), 32'h0E0E_000A, "R9 engine write alone");

    wr(w(1), 32'h7777_7777);
    wr(w(4), 32'd1); wr(w(12'h200), 32'h5555_5555);
    do_reset();
    rd(w(1), 32'h0, "R10 config cleared");
    rd(w(12'h109), 32'h0, "R10 gpr cleared");
    eng_code_raddr = 11'd512;
    #1 check(eng_code_rdata == 32'h0, "R10 microcode cleared", eng_code_rdata, 0);
    eng_code_raddr = 11'd2047;
    #1 check(eng_code_rdata == 32'h0, "R10 microcode top cleared", eng_code_rdata, 0);

    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule